// File: doc/BRIEF.md
# Parallel Word-Plane Compute Grid

The block is a two-dimensional grid of processing cells, 32 rows by 32 columns by default. Every cell keeps four 16-bit words, so the grid as a whole holds four word planes: two operand planes that can swap roles (A and C), a shared second-operand plane (B), and a scratch plane (T) that catches each result before it is committed. A single controller sends one elementwise operation to all cells at once. The direction bit picks the role of each plane. Direction 0 combines A with B and writes the result to C. Direction 1 combines C with B and writes the result to A. A chain of operations can therefore alternate between the two planes without moving any data.

An operation takes two cycles. In the first cycle every cell computes its result into T. In the second cycle T is copied into the destination plane. A row-wide port lets surrounding logic fill the A, B and C planes one row at a time while the grid is idle. A second row-wide port returns any plane's row one cycle after it is requested.

Top module: `apgrid_top`

## Requirements
- R1: After reset all four planes hold zero, `busy` is low and `rd_valid` is low.
- R2: When the grid is idle and `ld_en` is high, the row of plane `ld_plane` (0 = A, 1 = B, 2 = C) at index `ld_row` takes `ld_data`. Column c is taken from bits [16c+15:16c]. The code 3 (T) writes nothing.
- R3: A load request that arrives while `busy` is high changes no plane.
- R4: A cycle with `rd_req` high is followed one cycle later by `rd_valid` high and `rd_data` holding the pre-edge row `rd_row` of plane `rd_plane` (0 = A, 1 = B, 2 = C, 3 = T), with column c in bits [16c+15:16c]. When `rd_req` is low, `rd_valid` is low in the next cycle.
- R5: An operation accepted at a clock edge sets `busy` high for exactly the next two cycles. After that `busy` returns low.
- R6: Operation requests made while `busy` is high are ignored.
- R7: With `op_dir` = 0, each cell's C becomes op(A, B), and A is left unchanged.
- R8: With `op_dir` = 1, each cell's A becomes op(C, B), and C is left unchanged.
- R9: After an operation, T holds the result of that operation until the next operation is computed.
- R10: `op_code` selects the operation: 0 is add, 1 is subtract (first operand minus B), 2 is AND, 3 is OR and 4 is XOR, all with 16-bit wraparound. Codes 5 to 7 are rejected: `busy` stays low and no plane changes.
- R11: An operation never modifies the B plane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_req | input | 1 | Start an operation |
| op_code | input | 3 | Operation select |
| op_dir | input | 1 | 0: A,B to C; 1: C,B to A |
| busy | output | 1 | Operation in progress |
| ld_en | input | 1 | Row load strobe |
| ld_plane | input | 2 | Load target plane |
| ld_row | input | 5 | Load row index |
| ld_data | input | 512 | Row of words to load |
| rd_req | input | 1 | Row read strobe |
| rd_plane | input | 2 | Read source plane |
| rd_row | input | 5 | Read row index |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 512 | Row of words read |

## Verification
The operation path is run with random operand planes for every opcode in both directions. This separates the opcodes from one another and catches swapped operands or a wrong destination, because all four planes are read back after each operation. Operands at the edges of the 16-bit range (all ones plus one, and zero minus one) show whether wraparound is correct. Three further cases check that nothing happens when it should not: rejected opcode values, loads and operations issued while busy, and a load aimed at the scratch plane.

// File: rtl/apgrid_pkg.sv
package apgrid_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4
    } alu_op_e;

    typedef enum logic [1:0] {
        PL_A = 2'd0,
        PL_B = 2'd1,
        PL_C = 2'd2,
        PL_T = 2'd3
    } plane_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_CALC   = 2'd1,
        PH_COMMIT = 2'd2
    } phase_e;

    localparam logic DIR_TO_C = 1'b0;
    localparam logic DIR_TO_A = 1'b1;

    function automatic logic op_supported(input logic [2:0] code);
        return code <= 3'd4;
    endfunction

endpackage

// File: rtl/apgrid_ctrl.sv
module apgrid_ctrl
    import apgrid_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_req,
    input  logic [2:0] op_code,
    input  logic       op_dir,
    output logic       busy,
    output logic       idle,
    output logic       calc_en,
    output logic       commit_en,
    output alu_op_e    op,
    output logic       dir
);

    typedef struct packed {
        phase_e  phase;
        alu_op_e op;
        logic    dir;
    } ctrl_s;

    ctrl_s ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        unique case (ctrl_q.phase)
            PH_IDLE: begin
                if (op_req && op_supported(op_code)) begin
                    ctrl_d.phase = PH_CALC;
                    ctrl_d.op    = alu_op_e'(op_code);
                    ctrl_d.dir   = op_dir;
                end
            end
            PH_CALC:   ctrl_d.phase = PH_COMMIT;
            PH_COMMIT: ctrl_d.phase = PH_IDLE;
            default:   ctrl_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '{phase: PH_IDLE, op: OP_ADD, dir: DIR_TO_C};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign idle      = (ctrl_q.phase == PH_IDLE);
    assign busy      = !idle;
    assign calc_en   = (ctrl_q.phase == PH_CALC);
    assign commit_en = (ctrl_q.phase == PH_COMMIT);
    assign op        = ctrl_q.op;
    assign dir       = ctrl_q.dir;

    // R5
    calc_then_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        calc_en |=> commit_en);

    // R5
    commit_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |=> idle);

    // R6
    busy_holds_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(op) && $stable(dir)));

    // R10
    reject_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && op_req && (op_code > 3'd4)) |=> idle);

endmodule

// File: rtl/apgrid_cell.sv
module apgrid_cell
    import apgrid_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         calc_en,
    input  logic         commit_en,
    input  logic         dir,
    input  alu_op_e      op,
    input  logic         ld_en,
    input  plane_e       ld_plane,
    input  logic [W-1:0] ld_word,
    output logic [W-1:0] a_o,
    output logic [W-1:0] b_o,
    output logic [W-1:0] c_o,
    output logic [W-1:0] t_o
);

    typedef struct packed {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] c;
        logic [W-1:0] t;
    } cell_s;

    cell_s cell_d, cell_q;
    logic [W-1:0] lhs, res;

    always_comb begin
        lhs = (dir == DIR_TO_A) ? cell_q.c : cell_q.a;
        unique case (op)
            OP_ADD:  res = lhs + cell_q.b;
            OP_SUB:  res = lhs - cell_q.b;
            OP_AND:  res = lhs & cell_q.b;
            OP_OR:   res = lhs | cell_q.b;
            OP_XOR:  res = lhs ^ cell_q.b;
            default: res = '0;
        endcase

        cell_d = cell_q;
        if (calc_en) begin
            cell_d.t = res;
        end
        if (commit_en) begin
            if (dir == DIR_TO_A) cell_d.a = cell_q.t;
            else                 cell_d.c = cell_q.t;
        end
        if (ld_en) begin
            unique case (ld_plane)
                PL_A:    cell_d.a = ld_word;
                PL_B:    cell_d.b = ld_word;
                PL_C:    cell_d.c = ld_word;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cell_q <= '0;
        end else begin
            cell_q <= cell_d;
        end
    end

    assign a_o = cell_q.a;
    assign b_o = cell_q.b;
    assign c_o = cell_q.c;
    assign t_o = cell_q.t;

    // R11
    b_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (calc_en || commit_en) |=> $stable(cell_q.b));

    // R7
    a_kept_dir_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_en && dir == DIR_TO_C) |=> $stable(cell_q.a));

    // R8
    c_kept_dir_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_en && dir == DIR_TO_A) |=> $stable(cell_q.c));

    // R9
    t_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_en && dir == DIR_TO_C) |=> (cell_q.c == cell_q.t));

endmodule

// File: rtl/apgrid_top.sv
module apgrid_top
    import apgrid_pkg::*;
#(
    parameter  int ROWS = 32,
    parameter  int COLS = 32,
    parameter  int W    = 16,
    localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int LINE = COLS * W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_req,
    input  logic [2:0]      op_code,
    input  logic            op_dir,
    output logic            busy,
    input  logic            ld_en,
    input  logic [1:0]      ld_plane,
    input  logic [RW-1:0]   ld_row,
    input  logic [LINE-1:0] ld_data,
    input  logic            rd_req,
    input  logic [1:0]      rd_plane,
    input  logic [RW-1:0]   rd_row,
    output logic            rd_valid,
    output logic [LINE-1:0] rd_data
);

    logic    idle, calc_en, commit_en, dir, ld_go;
    alu_op_e op;

    logic [W-1:0] pa [ROWS][COLS];
    logic [W-1:0] pb [ROWS][COLS];
    logic [W-1:0] pc [ROWS][COLS];
    logic [W-1:0] pt [ROWS][COLS];

    apgrid_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_req    (op_req),
        .op_code   (op_code),
        .op_dir    (op_dir),
        .busy      (busy),
        .idle      (idle),
        .calc_en   (calc_en),
        .commit_en (commit_en),
        .op        (op),
        .dir       (dir)
    );

    assign ld_go = ld_en && idle;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            apgrid_cell #(.W(W)) u_cell (
                .clk       (clk),
                .rst_n     (rst_n),
                .calc_en   (calc_en),
                .commit_en (commit_en),
                .dir       (dir),
                .op        (op),
                .ld_en     (ld_go && (ld_row == RW'(r))),
                .ld_plane  (plane_e'(ld_plane)),
                .ld_word   (ld_data[c*W +: W]),
                .a_o       (pa[r][c]),
                .b_o       (pb[r][c]),
                .c_o       (pc[r][c]),
                .t_o       (pt[r][c])
            );
        end
    end

    typedef struct packed {
        logic            valid;
        logic [LINE-1:0] data;
    } rd_s;

    rd_s rd_d, rd_q;

    always_comb begin
        rd_d       = rd_q;
        rd_d.valid = rd_req;
        if (rd_req) begin
            for (int c = 0; c < COLS; c++) begin
                unique case (plane_e'(rd_plane))
                    PL_A:    rd_d.data[c*W +: W] = pa[rd_row][c];
                    PL_B:    rd_d.data[c*W +: W] = pb[rd_row][c];
                    PL_C:    rd_d.data[c*W +: W] = pc[rd_row][c];
                    default: rd_d.data[c*W +: W] = pt[rd_row][c];
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_valid = rd_q.valid;
    assign rd_data  = rd_q.data;

    // R4
    rd_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);

    // R4
    rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);

    // R5
    busy_two_cycles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy);

endmodule

// File: tb/tb_apgrid_top.sv
`timescale 1ns/1ps
module tb_apgrid_top;

    localparam int N    = 32;
    localparam int LINE = N * 16;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            op_req, op_dir;
    logic [2:0]      op_code;
    logic            busy;
    logic            ld_en;
    logic [1:0]      ld_plane;
    logic [4:0]      ld_row;
    logic [LINE-1:0] ld_data;
    logic            rd_req;
    logic [1:0]      rd_plane;
    logic [4:0]      rd_row;
    logic            rd_valid;
    logic [LINE-1:0] rd_data;

    always #4 clk = ~clk;

    apgrid_top dut (
        .clk(clk), .rst_n(rst_n), .op_req(op_req), .op_code(op_code), .op_dir(op_dir),
        .busy(busy), .ld_en(ld_en), .ld_plane(ld_plane), .ld_row(ld_row), .ld_data(ld_data),
        .rd_req(rd_req), .rd_plane(rd_plane), .rd_row(rd_row), .rd_valid(rd_valid),
        .rd_data(rd_data)
    );

    // reference planes: 0 A, 1 B, 2 C, 3 T
    logic [15:0] m [4][N][N];
    int          ph;
    logic [2:0]  lop;
    logic        ldir;
    int          compared = 0;
    int          mismatched = 0;
    string       dtag = "R1";

    function automatic logic [15:0] ref_alu(logic [2:0] code, logic [15:0] x, logic [15:0] y);
        case (code)
            3'd0:    return x + y;
            3'd1:    return x - y;
            3'd2:    return x & y;
            3'd3:    return x | y;
            default: return x ^ y;
        endcase
    endfunction

    task automatic check(string tag, logic [LINE-1:0] act, logic [LINE-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        logic [LINE-1:0] row;
        logic            rq;
        int              nph;
        rq  = rd_req;
        row = '0;
        for (int c = 0; c < N; c++) row[c*16 +: 16] = m[rd_plane][rd_row][c];
        nph = ph;
        if (ph == 1) begin
            for (int r = 0; r < N; r++)
                for (int c = 0; c < N; c++)
                    m[3][r][c] = ref_alu(lop, ldir ? m[2][r][c] : m[0][r][c], m[1][r][c]);
            nph = 2;
        end else if (ph == 2) begin
            for (int r = 0; r < N; r++)
                for (int c = 0; c < N; c++)
                    if (ldir) m[0][r][c] = m[3][r][c];
                    else      m[2][r][c] = m[3][r][c];
            nph = 0;
        end else begin
            if (ld_en && ld_plane != 2'd3)
                for (int c = 0; c < N; c++) m[ld_plane][ld_row][c] = ld_data[c*16 +: 16];
            if (op_req && op_code < 3'd5) begin
                lop  = op_code;
                ldir = op_dir;
                nph  = 1;
            end
        end
        ph = nph;
        @(posedge clk);
        @(negedge clk);
        check("R5 busy", LINE'(busy), LINE'(ph != 0));
        check("R4 rd_valid", LINE'(rd_valid), LINE'(rq));
        if (rq) check({dtag, " rd_data"}, rd_data, row);
    endtask

    task automatic read_all(string tag);
        dtag = tag;
        for (int p = 0; p < 4; p++)
            for (int r = 0; r < N; r++) begin
                rd_req = 1'b1; rd_plane = 2'(p); rd_row = 5'(r);
                tick();
            end
        rd_req = 1'b0;
    endtask

    function automatic logic [LINE-1:0] rand_row();
        logic [LINE-1:0] v;
        for (int i = 0; i < LINE / 32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic load_row(int p, int r, logic [LINE-1:0] v);
        ld_en = 1'b1; ld_plane = 2'(p); ld_row = 5'(r); ld_data = v;
        tick();
        ld_en = 1'b0;
    endtask

    task automatic run_op(int code, logic d);
        op_req = 1'b1; op_code = 3'(code); op_dir = d;
        tick();
        op_req = 1'b0;
        tick();
        tick();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        void'($urandom(7));
        rst_n = 1'b0; op_req = 1'b0; op_code = '0; op_dir = 1'b0;
        ld_en = 1'b0; ld_plane = '0; ld_row = '0; ld_data = '0;
        rd_req = 1'b0; rd_plane = '0; rd_row = '0;
        ph = 0; lop = '0; ldir = 1'b0;
        for (int p = 0; p < 4; p++)
            for (int r = 0; r < N; r++)
                for (int c = 0; c < N; c++) m[p][r][c] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 busy after reset", LINE'(busy), '0);
        check("R1 rd_valid after reset", LINE'(rd_valid), '0);
        read_all("R1");

        // R2: fill A, B, C; then a write aimed at T must be dropped
        for (int p = 0; p < 3; p++)
            for (int r = 0; r < N; r++) load_row(p, r, rand_row());
        load_row(3, 5, rand_row());
        read_all("R2");

        // R7 R9 R11: direction 0 add
        run_op(0, 1'b0);
        read_all("R7 R9 R11");

        // R10 R7 R8: every opcode, both directions
        for (int code = 0; code < 5; code++) begin
            run_op(code, 1'b0);
            read_all("R10 R7");
            run_op(code, 1'b1);
            read_all("R10 R8");
        end

        // R10: wraparound at the 16-bit edges
        for (int r = 0; r < N; r++) begin
            load_row(0, r, {LINE{1'b1}});
            load_row(1, r, {N{16'h0001}});
        end
        run_op(0, 1'b0);
        read_all("R10 wrap add");
        run_op(1, 1'b1);
        read_all("R10 wrap sub");

        // R10: codes 5..7 rejected
        for (int r = 0; r < N; r++) load_row(2, r, rand_row());
        for (int code = 5; code < 8; code++) begin
            op_req = 1'b1; op_code = 3'(code); op_dir = 1'b0;
            tick();
            op_req = 1'b0;
            tick();
        end
        read_all("R10 rejected");

        // R3 R6: load and second op while busy
        op_req = 1'b1; op_code = 3'd4; op_dir = 1'b1;
        tick();
        op_code = 3'd0; op_dir = 1'b0;
        ld_en = 1'b1; ld_plane = 2'd1; ld_row = 5'd3; ld_data = rand_row();
        tick();
        ld_plane = 2'd0; ld_row = 5'd9;
        tick();
        op_req = 1'b0; ld_en = 1'b0;
        tick();
        read_all("R3 R6");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule